// File: doc/BRIEF.md
# Descriptor Ring Activation Poller

This block is the command and polling front end of a DMA engine for an Ethernet-style controller. It has a receive channel and a transmit channel. Each channel has an "active" command bit that software sets by writing the channel's register. While that bit is set and the controller enable is on, the channel walks its ring of buffer descriptors one at a time. For each descriptor it first fetches the status. If the descriptor is available, it then hands the descriptor to the data path through a process handshake.

When a fetched descriptor is not yet available, the channel drops its active bit and goes idle. It keeps its ring position, so the next software write resumes at the same descriptor and reads it again. A receive descriptor is available when its empty flag is set. A transmit descriptor is available when its ready flag is set. A descriptor with its wrap flag set sends the pointer back to the ring base. Any other descriptor advances the pointer by a fixed stride.

The two channels clear their bits under different conditions. Dropping the controller enable idles both channels and rewinds both pointers. The soft-reset command affects only the transmit channel.

Top module: `dring_activator`

## Requirements
- R1: After reset both active bits read 0, no fetch or process request is raised, and both descriptor addresses equal their ring bases.
- R2: A read at offset 0x10 returns the receive active bit in bit 24, and a read at offset 0x14 returns the transmit active bit in bit 24. All other bits read 0, and every other offset reads 0.
- R3: A write strobe at offset 0x10 or 0x14 sets that channel's active bit on the next edge. This holds only while the enable is high, and for transmit only while soft reset is low. No data value is involved.
- R4: A fetch request is raised only while the channel's active bit is set and the enable is high. It rises one cycle after an idle channel sees its bit set, and it holds until the descriptor-ready input is seen.
- R5: A fetched descriptor whose available flag is 1 raises the process request on the next cycle. The request holds until process-done is seen, and the channel then fetches the next descriptor on the following cycle.
- R6: A fetched descriptor whose available flag is 0 clears the active bit, returns the channel to idle and leaves the pointer unchanged.
- R7: When process-done is seen, the pointer returns to the ring base if that descriptor's wrap flag was 1. Otherwise the pointer advances by DESC_BYTES.
- R8: Setting the active bit on an idle channel fetches again from the current pointer, so the same descriptor is re-read.
- R9: A write that coincides with an unavailable fetch leaves the active bit set. The channel then re-fetches the same descriptor.
- R10: While the enable is low, both active bits are held at 0, both channels are idle and both pointers are held at their bases.
- R11: While soft reset is high, the transmit bit is held at 0 and the transmit channel is idle, but its pointer is kept. The receive channel is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Controller enable |
| srst_i | input | 1 | Soft-reset command (transmit only) |
| reg_addr_i | input | RA_W | Register bus byte offset |
| reg_we_i | input | 1 | Register write strobe |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| rx_desc_req_o | output | 1 | Receive descriptor status fetch request |
| rx_desc_addr_o | output | AW | Receive ring pointer |
| rx_desc_rdy_i | input | 1 | Receive status valid |
| rx_desc_empty_i | input | 1 | Receive descriptor empty flag |
| rx_desc_wrap_i | input | 1 | Receive descriptor wrap flag |
| rx_proc_req_o | output | 1 | Receive process request |
| rx_proc_done_i | input | 1 | Receive process done |
| tx_desc_req_o | output | 1 | Transmit descriptor status fetch request |
| tx_desc_addr_o | output | AW | Transmit ring pointer |
| tx_desc_rdy_i | input | 1 | Transmit status valid |
| tx_desc_ready_i | input | 1 | Transmit descriptor ready flag |
| tx_desc_wrap_i | input | 1 | Transmit descriptor wrap flag |
| tx_proc_req_o | output | 1 | Transmit process request |
| tx_proc_done_i | input | 1 | Transmit process done |

## Verification
The bench builds the block with a 32-bit address and ring bases at 0x1000 and 0x2000. It keeps the 8-byte stride and models a four-entry ring whose last entry carries the wrap flag. With such a short ring the wrap-back happens every few descriptors. Software refills and hardware consumption then collide often enough that unavailable fetches, resumes and write-versus-clear coincidences all occur many times. Enable drops and soft-reset pulses land in every channel state, so pointer rewind and retention are both compared against the reference model.

// File: rtl/dring_pkg.sv
package dring_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_PROC  = 2'd2
  } poll_st_e;

  localparam int unsigned CH_RX = 0;
  localparam int unsigned CH_TX = 1;
  localparam int unsigned N_CH  = 2;
endpackage

// File: rtl/dring_regif.sv
module dring_regif #(
  parameter int unsigned RA_W    = 8,
  parameter int unsigned DW      = 32,
  parameter int unsigned ACT_BIT = 24,
  parameter logic [RA_W-1:0] RX_OFS = 8'h10,
  parameter logic [RA_W-1:0] TX_OFS = 8'h14
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [RA_W-1:0] addr_i,
  input  logic            we_i,
  input  logic [1:0]      act_i,
  output logic [1:0]      set_o,
  output logic [DW-1:0]   rdata_o
);
  logic hit_rx, hit_tx;

  assign hit_rx   = (addr_i == RX_OFS);
  assign hit_tx   = (addr_i == TX_OFS);
  assign set_o[0] = we_i & hit_rx;
  assign set_o[1] = we_i & hit_tx;

  always_comb begin
    rdata_o = '0;
    if (hit_rx) rdata_o[ACT_BIT] = act_i[0];
    if (hit_tx) rdata_o[ACT_BIT] = act_i[1];
  end

  // R2
  rsvd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(rdata_o) <= 1);
  // R2
  miss_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hit_rx && !hit_tx) |-> (rdata_o == '0));
endmodule

// File: rtl/dring_chan.sv
module dring_chan
  import dring_pkg::*;
#(
  parameter int unsigned     AW         = 32,
  parameter logic [AW-1:0]   BASE       = '0,
  parameter int unsigned     DESC_BYTES = 8,
  parameter bit              SRST_CLR   = 1'b0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          srst_i,
  input  logic          set_i,
  input  logic          desc_rdy_i,
  input  logic          desc_avail_i,
  input  logic          desc_wrap_i,
  input  logic          proc_done_i,
  output logic          act_o,
  output logic          desc_req_o,
  output logic [AW-1:0] desc_addr_o,
  output logic          proc_req_o
);
  localparam logic [AW-1:0] STEP = AW'(DESC_BYTES);

  poll_st_e      st_q;
  logic          act_q, wrap_q, clr, miss;
  logic [AW-1:0] ptr_q;

  assign clr  = !en_i || (SRST_CLR && srst_i);
  assign miss = (st_q == ST_FETCH) && desc_rdy_i && !desc_avail_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      act_q  <= 1'b0;
      wrap_q <= 1'b0;
      ptr_q  <= BASE;
    end else if (clr) begin
      st_q  <= ST_IDLE;
      act_q <= 1'b0;
      if (!en_i) ptr_q <= BASE;
    end else begin
      // software set beats the hardware clear
      act_q <= set_i ? 1'b1 : (miss ? 1'b0 : act_q);
      unique case (st_q)
        ST_IDLE:  if (act_q) st_q <= ST_FETCH;
        ST_FETCH: if (desc_rdy_i) begin
          if (desc_avail_i) begin
            st_q   <= ST_PROC;
            wrap_q <= desc_wrap_i;
          end else begin
            st_q <= ST_IDLE;
          end
        end
        ST_PROC:  if (proc_done_i) begin
          ptr_q <= wrap_q ? BASE : ptr_q + STEP;
          st_q  <= ST_FETCH;
        end
        default:  st_q <= ST_IDLE;
      endcase
    end
  end

  assign act_o       = act_q;
  assign desc_req_o  = (st_q == ST_FETCH);
  assign proc_req_o  = (st_q == ST_PROC);
  assign desc_addr_o = ptr_q;

  // R4
  req_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_req_o |-> act_q);
  // R4
  one_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({desc_req_o, proc_req_o}));
  // R3
  set_takes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !clr) |=> act_q);
  // R6
  miss_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (desc_req_o && desc_rdy_i && !desc_avail_i && !set_i && !clr) |=> (!act_q && !desc_req_o));
  // R6
  miss_hold_ptr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (desc_req_o && desc_rdy_i && !desc_avail_i && en_i) |=> $stable(desc_addr_o));
  // R7
  wrap_base_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (proc_req_o && proc_done_i && wrap_q && !clr) |=> (desc_addr_o == BASE));
  // R10
  en_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!act_q && !desc_req_o && !proc_req_o && desc_addr_o == BASE));
endmodule

// File: rtl/dring_activator.sv
module dring_activator
  import dring_pkg::*;
#(
  parameter int unsigned   AW         = 32,
  parameter int unsigned   RA_W       = 8,
  parameter int unsigned   DESC_BYTES = 8,
  parameter logic [AW-1:0] RX_BASE    = 32'h0000_1000,
  parameter logic [AW-1:0] TX_BASE    = 32'h0000_2000
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            srst_i,
  input  logic [RA_W-1:0] reg_addr_i,
  input  logic            reg_we_i,
  output logic [31:0]     reg_rdata_o,
  output logic            rx_desc_req_o,
  output logic [AW-1:0]   rx_desc_addr_o,
  input  logic            rx_desc_rdy_i,
  input  logic            rx_desc_empty_i,
  input  logic            rx_desc_wrap_i,
  output logic            rx_proc_req_o,
  input  logic            rx_proc_done_i,
  output logic            tx_desc_req_o,
  output logic [AW-1:0]   tx_desc_addr_o,
  input  logic            tx_desc_rdy_i,
  input  logic            tx_desc_ready_i,
  input  logic            tx_desc_wrap_i,
  output logic            tx_proc_req_o,
  input  logic            tx_proc_done_i
);
  logic [N_CH-1:0] set, act, req, rdy, avail, wrap, preq, pdone;
  logic [AW-1:0]   addr [N_CH];

  assign rdy   = {tx_desc_rdy_i,   rx_desc_rdy_i};
  assign avail = {tx_desc_ready_i, rx_desc_empty_i};
  assign wrap  = {tx_desc_wrap_i,  rx_desc_wrap_i};
  assign pdone = {tx_proc_done_i,  rx_proc_done_i};

  dring_regif #(
    .RA_W(RA_W), .DW(32), .ACT_BIT(24),
    .RX_OFS(RA_W'(8'h10)), .TX_OFS(RA_W'(8'h14))
  ) u_regif (
    .clk_i, .rst_ni,
    .addr_i (reg_addr_i),
    .we_i   (reg_we_i),
    .act_i  (act),
    .set_o  (set),
    .rdata_o(reg_rdata_o)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    localparam logic [AW-1:0] B = (g == CH_RX) ? RX_BASE : TX_BASE;
    dring_chan #(
      .AW(AW), .BASE(B), .DESC_BYTES(DESC_BYTES), .SRST_CLR(g == CH_TX)
    ) u_chan (
      .clk_i, .rst_ni, .en_i, .srst_i,
      .set_i       (set[g]),
      .desc_rdy_i  (rdy[g]),
      .desc_avail_i(avail[g]),
      .desc_wrap_i (wrap[g]),
      .proc_done_i (pdone[g]),
      .act_o       (act[g]),
      .desc_req_o  (req[g]),
      .desc_addr_o (addr[g]),
      .proc_req_o  (preq[g])
    );
  end

  assign rx_desc_req_o  = req[CH_RX];
  assign tx_desc_req_o  = req[CH_TX];
  assign rx_desc_addr_o = addr[CH_RX];
  assign tx_desc_addr_o = addr[CH_TX];
  assign rx_proc_req_o  = preq[CH_RX];
  assign tx_proc_req_o  = preq[CH_TX];

  // R11
  srst_rx_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (srst_i && en_i && act[CH_RX] && !(req[CH_RX] && rdy[CH_RX] && !avail[CH_RX])) |=> act[CH_RX]);
  // R11
  srst_tx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_i |=> (!act[CH_TX] && !req[CH_TX] && !preq[CH_TX]));
endmodule

// File: tb/tb_dring_activator.sv
`timescale 1ns/1ps
module tb_dring_activator;
  localparam int AW = 32, RA_W = 8, NDESC = 4, NCYC = 4000;
  localparam logic [31:0] RXB = 32'h0000_1000, TXB = 32'h0000_2000;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, en, srst, we;
  logic [RA_W-1:0] raddr;
  logic [31:0] rdata;
  logic rx_req, rx_rdy, rx_empty, rx_wrap, rx_preq, rx_done;
  logic tx_req, tx_rdy, tx_ready, tx_wrap, tx_preq, tx_done;
  logic [AW-1:0] rx_addr, tx_addr;

  dring_activator dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .srst_i(srst),
    .reg_addr_i(raddr), .reg_we_i(we), .reg_rdata_o(rdata),
    .rx_desc_req_o(rx_req), .rx_desc_addr_o(rx_addr), .rx_desc_rdy_i(rx_rdy),
    .rx_desc_empty_i(rx_empty), .rx_desc_wrap_i(rx_wrap),
    .rx_proc_req_o(rx_preq), .rx_proc_done_i(rx_done),
    .tx_desc_req_o(tx_req), .tx_desc_addr_o(tx_addr), .tx_desc_rdy_i(tx_rdy),
    .tx_desc_ready_i(tx_ready), .tx_desc_wrap_i(tx_wrap),
    .tx_proc_req_o(tx_preq), .tx_proc_done_i(tx_done)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit run = 0, done_f = 0;
  string rd_tag = "R2";

  int      m_st  [2];
  bit      m_act [2];
  bit      m_wq  [2];
  longint  m_ptr [2];
  string   m_tag [2];
  bit      avail [2][NDESC];

  task automatic check(input string tag, input string what, input longint got, input longint exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", tag, what, got, exp, cyc);
    end
  endtask

  function automatic longint base_of(input int c);
    return (c == 0) ? longint'(RXB) : longint'(TXB);
  endfunction

  // behavioural reference step for one channel, one clock
  task automatic model_step(input int c, input bit e, input bit s, input bit set,
                            input bit rdy, input bit flag, input bit wr, input bit dn);
    bit nact;
    bit clr;
    clr = !e || (c == 1 && s);
    m_tag[c] = "R5";
    if (clr) begin
      m_tag[c] = !e ? "R10" : "R11";
      m_act[c] = 0; m_st[c] = 0;
      if (!e) m_ptr[c] = base_of(c);
      return;
    end
    nact = m_act[c];
    if (m_st[c] == 0) begin
      if (m_act[c]) begin m_st[c] = 1; m_tag[c] = "R8"; end
      else if (set) m_tag[c] = "R3";
    end else if (m_st[c] == 1) begin
      if (rdy) begin
        if (flag) begin m_st[c] = 2; m_wq[c] = wr; end
        else begin m_st[c] = 0; nact = 0; m_tag[c] = set ? "R9" : "R6"; end
      end else m_tag[c] = "R4";
    end else begin
      if (dn) begin
        m_ptr[c] = m_wq[c] ? base_of(c) : m_ptr[c] + 8;
        m_st[c] = 1;
        if (m_wq[c]) m_tag[c] = "R7";
      end
    end
    if (set) nact = 1;
    m_act[c] = nact;
  endtask

  function automatic int idx_of(input int c, input logic [AW-1:0] a);
    return int'(((longint'(a) - base_of(c)) / 8) % NDESC);
  endfunction

  always @(negedge clk) begin
    if (run && !done_f) begin
      longint exp_rd;
      bit g1, g2, g3, g4;
      int ix;
      cyc++;
      // compare
      exp_rd = (raddr == 8'h10) ? (longint'(m_act[0]) << 24) :
               (raddr == 8'h14) ? (longint'(m_act[1]) << 24) : 0;
      check(rd_tag, "reg_rdata", longint'(rdata), exp_rd);
      check({"R4/", m_tag[0]}, "rx_desc_req", rx_req, m_st[0] == 1);
      check({"R5/", m_tag[0]}, "rx_proc_req", rx_preq, m_st[0] == 2);
      check({"R7/", m_tag[0]}, "rx_desc_addr", longint'(rx_addr), m_ptr[0]);
      check({"R4/", m_tag[1]}, "tx_desc_req", tx_req, m_st[1] == 1);
      check({"R5/", m_tag[1]}, "tx_proc_req", tx_preq, m_st[1] == 2);
      check({"R7/", m_tag[1]}, "tx_desc_addr", longint'(tx_addr), m_ptr[1]);

      // new stimulus
      en   = !((cyc % 700) >= 600 && (cyc % 700) < 620);
      srst = ($urandom % 40) == 0;
      we   = ($urandom % 4) == 0;
      case ($urandom % 4)
        0: raddr = 8'h10;
        1: raddr = 8'h14;
        2: raddr = 8'h00;
        default: raddr = 8'h18;
      endcase
      rd_tag = (we && (raddr == 8'h10 || raddr == 8'h14)) ? "R3" : "R2";
      if (($urandom % 6) == 0) avail[$urandom % 2][$urandom % NDESC] = 1'b1;
      g1 = $urandom % 2; g2 = $urandom % 2; g3 = $urandom % 2; g4 = $urandom % 2;

      rx_rdy = rx_req & g1;
      ix = idx_of(0, rx_addr);
      rx_empty = avail[0][ix];
      rx_wrap  = (ix == NDESC - 1);
      rx_done  = rx_preq & g2;
      tx_rdy = tx_req & g3;
      ix = idx_of(1, tx_addr);
      tx_ready = avail[1][ix];
      tx_wrap  = (ix == NDESC - 1);
      tx_done  = tx_preq & g4;
      // consumed descriptors become unavailable again
      if (rx_done) avail[0][idx_of(0, rx_addr)] = 1'b0;
      if (tx_done) avail[1][idx_of(1, tx_addr)] = 1'b0;

      model_step(0, en, srst, we && raddr == 8'h10, rx_rdy, rx_empty, rx_wrap, rx_done);
      model_step(1, en, srst, we && raddr == 8'h14, tx_rdy, tx_ready, tx_wrap, tx_done);
    end
  end

  initial begin
    rst_n = 1'b0; en = 1'b0; srst = 1'b0; we = 1'b0; raddr = 8'h10;
    rx_rdy = 0; rx_empty = 0; rx_wrap = 0; rx_done = 0;
    tx_rdy = 0; tx_ready = 0; tx_wrap = 0; tx_done = 0;
    for (int c = 0; c < 2; c++) begin
      m_st[c] = 0; m_act[c] = 0; m_wq[c] = 0; m_ptr[c] = base_of(c); m_tag[c] = "R1";
      for (int i = 0; i < NDESC; i++) avail[c][i] = 1'b1;
    end
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "rx active read", longint'(rdata), 0);
    check("R1", "rx_desc_req", rx_req, 0);
    check("R1", "tx_desc_req", tx_req, 0);
    check("R1", "rx_proc_req", rx_preq, 0);
    check("R1", "tx_proc_req", tx_preq, 0);
    check("R1", "rx_desc_addr", longint'(rx_addr), longint'(RXB));
    check("R1", "tx_desc_addr", longint'(tx_addr), longint'(TXB));
    raddr = 8'h14;
    #1 check("R1", "tx active read", longint'(rdata), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    run = 1'b1;
    repeat (NCYC) @(negedge clk);
    done_f = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done_f) begin
      done_f = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule